// File: doc/BRIEF.md
# Banked Analog-Output Register Decoder

This block is the bus-side register interface of a multi-channel analog-output card. The host bus reaches it through a 16-entry word window, which is 32 bytes. Each access is a single-cycle read or write strobe with a word address. The block holds three configuration registers and an 8-line digital output latch. It builds a status word from FIFO levels, sticky interrupt flags and a serial PROM bit. It also issues single-cycle strobes to the FIFO and to a row of DAC channel latches.

A bank bit in configuration register 1 switches the shared low offsets from normal registers to clear-only strobes. With the bank bit clear, those offsets hold the digital output, configuration register 2 and configuration register 3. With the bank bit set, the same offsets clear the DMA terminal-count, interrupt 1 and interrupt 2 flags. The bank bit also chooses where a write at the FIFO offset goes: to the FIFO, or to DAC channel 0. DAC data arrives as two's-complement codes and is driven out as offset binary.

The digital lines are turned to output four at a time by two bits of configuration register 3. Digital input reads merge the pin values with the output latch according to those bits. After reset, the block clears the FIFO and all three interrupt sources once, with no software action.

Top module: `aout_reg_decoder`

## Requirements
- R1: While rst_ni is low, cfg1_o, cfg2_o, cfg3_o, dio_o, dio_oe_o, all strobes and all flags are zero, and every DAC code output is 0x800.
- R2: On the first clock edge after rst_ni rises, fifo_clr_o, tc_clr_o, int1_clr_o and int2_clr_o go high together for exactly one cycle.
- R3: The bank bit is bit 7 of configuration register 1, which is written at word address 5. While it is set, a write at word 0, 1 or 2 raises tc_clr_o, int1_clr_o or int2_clr_o in the cycle after the write. The write data is ignored, and the digital output latch, cfg2_o and cfg3_o keep their values.
- R4: While the bank bit is clear, a write at word 0 loads the digital output latch from the low 8 data bits. A write at word 1 loads cfg2_o and a write at word 2 loads cfg3_o. All three are visible in the cycle after the write.
- R5: A read at word 5 returns the status word. Bit 6 is FIFO half full, bit 5 FIFO empty, bit 4 FIFO full, bit 3 interrupt 2 flag, bit 2 interrupt 1 flag, bit 1 terminal-count flag and bit 0 the PROM bit. Bits 15 to 7 read 0.
- R6: Each of the three flags is set on the edge after its event input is high, and is cleared only by its own clear strobe. An event in the same cycle as the clear leaves the flag set.
- R7: A read at word 6 gives a one-cycle fifo_clr_o pulse in the next cycle. A write at word 6 with the bank bit clear gives a one-cycle fifo_wr_o pulse, with the data on fifo_wdata_o. With the bank bit set, the same write goes to DAC channel 0 instead.
- R8: A write at word 6+n, for n from 1 to NUM_DAC-1, loads DAC channel n whatever the bank bit. It also pulses dac_wr_o[n] for one cycle. That channel's dac_code_o slice then shows the low 12 written bits with bit 11 inverted.
- R9: dio_oe_o[3:0] all follow bit 2 of cfg3_o, and dio_oe_o[7:4] all follow bit 3 of cfg3_o.
- R10: A read at word 0 returns, for each line, the output latch bit if that line is enabled as output, and dio_i otherwise. The upper 8 bits read 0.
- R11: rdata_o is zero whenever rd_i is low, and on a read at any word other than 0 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for one cycle |
| rd_i | input | 1 | Read strobe for one cycle |
| word_addr_i | input | 4 | Word address inside the window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| cfg1_o | output | 16 | Configuration register 1 (bit 7 is the bank bit) |
| cfg2_o | output | 16 | Configuration register 2 |
| cfg3_o | output | 16 | Configuration register 3 |
| fifo_wr_o | output | 1 | FIFO push pulse |
| fifo_wdata_o | output | 16 | FIFO push data |
| fifo_clr_o | output | 1 | FIFO clear pulse |
| tc_clr_o | output | 1 | Terminal-count clear pulse |
| int1_clr_o | output | 1 | Interrupt 1 clear pulse |
| int2_clr_o | output | 1 | Interrupt 2 clear pulse |
| tc_evt_i | input | 1 | Terminal-count event |
| int1_evt_i | input | 1 | Interrupt 1 event |
| int2_evt_i | input | 1 | Interrupt 2 event |
| fifo_half_i | input | 1 | FIFO half full |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_full_i | input | 1 | FIFO full |
| prom_i | input | 1 | Serial PROM data bit |
| dac_wr_o | output | NUM_DAC | Per-channel DAC load pulse |
| dac_code_o | output | NUM_DAC*DAC_W | Offset-binary DAC codes, channel 0 in the low bits |
| dio_i | input | 8 | Digital line pin values |
| dio_o | output | 8 | Digital output latch |
| dio_oe_o | output | 8 | Digital output enables |

## Verification
The assertions assume that the bus never raises wr_i and rd_i in the same cycle. They also treat event inputs as level samples taken on each edge, so an event held for several cycles sets the flag again on every one of them. The stimulus keeps reads and writes exclusive in both its directed part and its random part. It drives events only at negedges and holds them for exactly one step.

Random configuration writes can flip the bank bit at any point. Both the banked and the unbanked meanings of the shared offsets are therefore reached in many orders, including a clear in the same cycle as a new event.

// File: rtl/aout_pkg.sv
package aout_pkg;
  localparam int AW = 4;
  localparam int DW = 16;

  localparam logic [AW-1:0] W_DIO  = 4'h0;
  localparam logic [AW-1:0] W_CFG2 = 4'h1;
  localparam logic [AW-1:0] W_CFG3 = 4'h2;
  localparam logic [AW-1:0] W_CFG1 = 4'h5;
  localparam logic [AW-1:0] W_FIFO = 4'h6;

  localparam int BANK_BIT  = 7;
  localparam int OE_LO_BIT = 2;

  localparam int FLG_TC   = 0;
  localparam int FLG_INT1 = 1;
  localparam int FLG_INT2 = 2;
  localparam int NUM_FLG  = 3;

  typedef struct packed {
    logic [NUM_FLG-1:0] clr;
    logic fifo_clr;
    logic fifo_wr;
    logic cfg1_we;
    logic cfg2_we;
    logic cfg3_we;
    logic dout_we;
  } dec_t;
endpackage

// File: rtl/aout_addr_dec.sv
module aout_addr_dec
  import aout_pkg::*;
#(
  parameter int NUM_DAC = 10
) (
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               bank_i,
  input  logic               init_i,
  output dec_t               req_o,
  output logic [NUM_DAC-1:0] dac_we_o
);
  logic wr_norm, wr_bank;

  assign wr_norm = wr_i & ~bank_i;
  assign wr_bank = wr_i & bank_i;

  always_comb begin
    req_o = '0;
    req_o.clr[FLG_TC]   = init_i | (wr_bank & (addr_i == W_DIO));
    req_o.clr[FLG_INT1] = init_i | (wr_bank & (addr_i == W_CFG2));
    req_o.clr[FLG_INT2] = init_i | (wr_bank & (addr_i == W_CFG3));
    req_o.fifo_clr      = init_i | (rd_i & (addr_i == W_FIFO));
    req_o.fifo_wr       = wr_norm & (addr_i == W_FIFO);
    req_o.cfg1_we       = wr_i & (addr_i == W_CFG1);
    req_o.cfg2_we       = wr_norm & (addr_i == W_CFG2);
    req_o.cfg3_we       = wr_norm & (addr_i == W_CFG3);
    req_o.dout_we       = wr_norm & (addr_i == W_DIO);
  end

  for (genvar n = 0; n < NUM_DAC; n++) begin : g_dac
    localparam logic [AW-1:0] OFS = AW'(int'(W_FIFO) + n);
    if (n == 0) begin : g_shared
      assign dac_we_o[n] = wr_bank & (addr_i == OFS);
    end else begin : g_plain
      assign dac_we_o[n] = wr_i & (addr_i == OFS);
    end
  end
endmodule

// File: rtl/aout_irq_flags.sv
module aout_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // set wins over clear so no event is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (evt_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/aout_dac_bank.sv
module aout_dac_bank #(
  parameter int NUM_DAC = 10,
  parameter int DAC_W   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_DAC-1:0]       we_i,
  input  logic [DAC_W-1:0]         wdata_i,
  output logic [NUM_DAC-1:0]       wr_o,
  output logic [NUM_DAC*DAC_W-1:0] code_o
);
  localparam logic [DAC_W-1:0] MSB_FLIP = DAC_W'(1) << (DAC_W - 1);

  for (genvar n = 0; n < NUM_DAC; n++) begin : g_ch
    logic [DAC_W-1:0] latch_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        latch_q <= '0;
        wr_o[n] <= 1'b0;
      end else begin
        wr_o[n] <= we_i[n];
        if (we_i[n]) latch_q <= wdata_i;
      end
    end
    // two's complement in, offset binary out
    assign code_o[n*DAC_W +: DAC_W] = latch_q ^ MSB_FLIP;
  end
endmodule

// File: rtl/aout_dio.sv
module aout_dio #(
  parameter int DIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DIO_W-1:0]   wdata_i,
  input  logic [DIO_W/4-1:0] nib_oe_i,
  input  logic [DIO_W-1:0]   pin_i,
  output logic [DIO_W-1:0]   dout_o,
  output logic [DIO_W-1:0]   oe_o,
  output logic [DIO_W-1:0]   din_o
);
  localparam int NIB = DIO_W / 4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_o <= '0;
    else if (we_i) dout_o <= wdata_i;
  end

  for (genvar g = 0; g < NIB; g++) begin : g_nib
    assign oe_o[g*4 +: 4] = {4{nib_oe_i[g]}};
  end

  assign din_o = (dout_o & oe_o) | (pin_i & ~oe_o);
endmodule

// File: rtl/aout_reg_decoder.sv
module aout_reg_decoder
  import aout_pkg::*;
#(
  parameter int NUM_DAC = 10,
  parameter int DAC_W   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [3:0]               word_addr_i,
  input  logic [15:0]              wdata_i,
  output logic [15:0]              rdata_o,
  output logic [15:0]              cfg1_o,
  output logic [15:0]              cfg2_o,
  output logic [15:0]              cfg3_o,
  output logic                     fifo_wr_o,
  output logic [15:0]              fifo_wdata_o,
  output logic                     fifo_clr_o,
  output logic                     tc_clr_o,
  output logic                     int1_clr_o,
  output logic                     int2_clr_o,
  input  logic                     tc_evt_i,
  input  logic                     int1_evt_i,
  input  logic                     int2_evt_i,
  input  logic                     fifo_half_i,
  input  logic                     fifo_empty_i,
  input  logic                     fifo_full_i,
  input  logic                     prom_i,
  output logic [NUM_DAC-1:0]       dac_wr_o,
  output logic [NUM_DAC*DAC_W-1:0] dac_code_o,
  input  logic [7:0]               dio_i,
  output logic [7:0]               dio_o,
  output logic [7:0]               dio_oe_o
);
  localparam int DIO_W = 8;
  localparam int NIB   = DIO_W / 4;

  dec_t                 req;
  logic [NUM_DAC-1:0]   dac_we;
  logic                 init_q;
  logic [NUM_FLG-1:0]   clr_q;
  logic [NUM_FLG-1:0]   flag_q;
  logic [NUM_FLG-1:0]   evt;
  logic [DIO_W-1:0]     din;
  logic [15:0]          status;

  // one cycle after reset: clear FIFO and all interrupt sources
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  aout_addr_dec #(.NUM_DAC(NUM_DAC)) u_dec (
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .addr_i   (word_addr_i),
    .bank_i   (cfg1_o[BANK_BIT]),
    .init_i   (init_q),
    .req_o    (req),
    .dac_we_o (dac_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_o       <= '0;
      cfg2_o       <= '0;
      cfg3_o       <= '0;
      clr_q        <= '0;
      fifo_clr_o   <= 1'b0;
      fifo_wr_o    <= 1'b0;
      fifo_wdata_o <= '0;
    end else begin
      if (req.cfg1_we) cfg1_o <= wdata_i;
      if (req.cfg2_we) cfg2_o <= wdata_i;
      if (req.cfg3_we) cfg3_o <= wdata_i;
      clr_q      <= req.clr;
      fifo_clr_o <= req.fifo_clr;
      fifo_wr_o  <= req.fifo_wr;
      if (req.fifo_wr) fifo_wdata_o <= wdata_i;
    end
  end

  assign tc_clr_o   = clr_q[FLG_TC];
  assign int1_clr_o = clr_q[FLG_INT1];
  assign int2_clr_o = clr_q[FLG_INT2];

  assign evt[FLG_TC]   = tc_evt_i;
  assign evt[FLG_INT1] = int1_evt_i;
  assign evt[FLG_INT2] = int2_evt_i;

  aout_irq_flags #(.N(NUM_FLG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (req.clr),
    .flag_o (flag_q)
  );

  aout_dac_bank #(.NUM_DAC(NUM_DAC), .DAC_W(DAC_W)) u_dac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dac_we),
    .wdata_i (wdata_i[DAC_W-1:0]),
    .wr_o    (dac_wr_o),
    .code_o  (dac_code_o)
  );

  aout_dio #(.DIO_W(DIO_W)) u_dio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (req.dout_we),
    .wdata_i  (wdata_i[DIO_W-1:0]),
    .nib_oe_i (cfg3_o[OE_LO_BIT +: NIB]),
    .pin_i    (dio_i),
    .dout_o   (dio_o),
    .oe_o     (dio_oe_o),
    .din_o    (din)
  );

  assign status = {9'b0, fifo_half_i, fifo_empty_i, fifo_full_i,
                   flag_q[FLG_INT2], flag_q[FLG_INT1], flag_q[FLG_TC], prom_i};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (word_addr_i)
        W_DIO:   rdata_o = {8'b0, din};
        W_CFG1:  rdata_o = status;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/aout_reg_decoder_chk.sv
module aout_reg_decoder_chk #(
  parameter int NUM_DAC = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               rd_i,
  input logic [3:0]         word_addr_i,
  input logic               bank_i,
  input logic [15:0]        cfg2_i,
  input logic               tc_clr_i,
  input logic               int1_clr_i,
  input logic               int1_evt_i,
  input logic               int1_flag_i,
  input logic               fifo_wr_i,
  input logic               fifo_clr_i,
  input logic [NUM_DAC-1:0] dac_wr_i
);
  AST_TC_CLR_BANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank_i && word_addr_i == 4'h0) |=> tc_clr_i); // R3

  AST_CFG2_HELD_BANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank_i && word_addr_i == 4'h1) |=> $stable(cfg2_i)); // R3

  AST_INT1_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int1_evt_i |=> int1_flag_i); // R6

  AST_INT1_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int1_clr_i && !$past(int1_evt_i)) |-> !int1_flag_i); // R6

  AST_FIFO_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && word_addr_i == 4'h6) |=> fifo_clr_i); // R7

  AST_FIFO_WR_UNBANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_i |-> !$past(bank_i)); // R7

  AST_DAC0_BANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_wr_i[0] |-> $past(bank_i)); // R7

  AST_DAC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dac_wr_i)); // R8
endmodule

bind aout_reg_decoder aout_reg_decoder_chk #(.NUM_DAC(NUM_DAC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .word_addr_i (word_addr_i),
  .bank_i      (cfg1_o[7]),
  .cfg2_i      (cfg2_o),
  .tc_clr_i    (tc_clr_o),
  .int1_clr_i  (int1_clr_o),
  .int1_evt_i  (int1_evt_i),
  .int1_flag_i (flag_q[1]),
  .fifo_wr_i   (fifo_wr_o),
  .fifo_clr_i  (fifo_clr_o),
  .dac_wr_i    (dac_wr_o)
);

// File: tb/aout_reg_decoder_tb.sv
module aout_reg_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 10;
  localparam int CW = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [3:0] word_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o, cfg1_o, cfg2_o, cfg3_o, fifo_wdata_o;
  logic fifo_wr_o, fifo_clr_o, tc_clr_o, int1_clr_o, int2_clr_o;
  logic tc_evt_i = 1'b0, int1_evt_i = 1'b0, int2_evt_i = 1'b0;
  logic fifo_half_i = 1'b0, fifo_empty_i = 1'b0, fifo_full_i = 1'b0, prom_i = 1'b0;
  logic [ND-1:0] dac_wr_o;
  logic [ND*CW-1:0] dac_code_o;
  logic [7:0] dio_i = '0, dio_o, dio_oe_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  aout_reg_decoder #(.NUM_DAC(ND), .DAC_W(CW)) u_dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_cfg1 = '0, m_cfg2 = '0, m_cfg3 = '0, m_fwd = '0;
  logic [7:0]  m_dout = '0;
  logic [2:0]  m_flag = '0, m_clr = '0;
  logic        m_fclr = 0, m_fwr = 0, m_init = 1;
  logic [CW-1:0] m_dac [ND];
  logic [ND-1:0] m_dwr = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_oe();
    return {{4{m_cfg3[3]}}, {4{m_cfg3[2]}}};
  endfunction

  task automatic model_edge();
    logic bank;
    logic [2:0] clr;
    bank = m_cfg1[7];
    clr[0] = m_init | (wr_i & bank & (word_addr_i == 4'd0));
    clr[1] = m_init | (wr_i & bank & (word_addr_i == 4'd1));
    clr[2] = m_init | (wr_i & bank & (word_addr_i == 4'd2));
    m_fclr = m_init | (rd_i & (word_addr_i == 4'd6));
    m_fwr  = wr_i & !bank & (word_addr_i == 4'd6);
    if (m_fwr) m_fwd = wdata_i;
    for (int n = 0; n < ND; n++) begin
      m_dwr[n] = wr_i && (int'(word_addr_i) == 6 + n) && (n != 0 || bank);
      if (m_dwr[n]) m_dac[n] = wdata_i[CW-1:0];
    end
    m_flag[0] = tc_evt_i   | (m_flag[0] & !clr[0]);
    m_flag[1] = int1_evt_i | (m_flag[1] & !clr[1]);
    m_flag[2] = int2_evt_i | (m_flag[2] & !clr[2]);
    m_clr = clr;
    if (wr_i && word_addr_i == 4'd5) m_cfg1 = wdata_i;
    if (wr_i && !bank && word_addr_i == 4'd1) m_cfg2 = wdata_i;
    if (wr_i && !bank && word_addr_i == 4'd2) m_cfg3 = wdata_i;
    if (wr_i && !bank && word_addr_i == 4'd0) m_dout = wdata_i[7:0];
    m_init = 0;
  endtask

  task automatic compare_all(input string strobe_tag);
    logic [15:0] exp_rd;
    string rtag;
    exp_rd = '0;
    rtag = "R11";
    if (rd_i && word_addr_i == 4'd0) begin
      exp_rd = {8'b0, (m_dout & m_oe()) | (dio_i & ~m_oe())};
      rtag = "R10";
    end else if (rd_i && word_addr_i == 4'd5) begin
      exp_rd = {9'b0, fifo_half_i, fifo_empty_i, fifo_full_i, m_flag[2], m_flag[1], m_flag[0], prom_i};
      rtag = "R5 R6";
    end
    chk(rtag, "rdata", 32'(rdata_o), 32'(exp_rd));
    chk("R3 R4", "cfg1", 32'(cfg1_o), 32'(m_cfg1));
    chk("R3 R4", "cfg2", 32'(cfg2_o), 32'(m_cfg2));
    chk("R3 R4", "cfg3", 32'(cfg3_o), 32'(m_cfg3));
    chk("R3 R4", "dio_o", 32'(dio_o), 32'(m_dout));
    chk("R9", "dio_oe", 32'(dio_oe_o), 32'(m_oe()));
    chk(strobe_tag, "clear strobes", 32'({tc_clr_o, int1_clr_o, int2_clr_o}),
        32'({m_clr[0], m_clr[1], m_clr[2]}));
    chk(strobe_tag, "fifo_clr", 32'(fifo_clr_o), 32'(m_fclr));
    chk("R7", "fifo_wr", 32'(fifo_wr_o), 32'(m_fwr));
    chk("R7", "fifo_wdata", 32'(fifo_wdata_o), 32'(m_fwd));
    chk("R7 R8", "dac_wr", 32'(dac_wr_o), 32'(m_dwr));
    for (int n = 0; n < ND; n++)
      chk("R8", "dac_code", 32'(dac_code_o[n*CW +: CW]), 32'(m_dac[n] ^ 12'h800));
  endtask

  task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                      input logic [15:0] d, input logic [2:0] evt);
    wr_i = wr; rd_i = rd; word_addr_i = a; wdata_i = d;
    {int2_evt_i, int1_evt_i, tc_evt_i} = evt;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare_all("R3");
  endtask

  task automatic flag_check(input string tag, input logic [2:0] exp);
    wr_i = 0; rd_i = 1; word_addr_i = 4'd5;
    {int2_evt_i, int1_evt_i, tc_evt_i} = '0;
    #1;
    chk(tag, "status flags", 32'(rdata_o[3:1]), 32'(exp));
  endtask

  initial begin
    for (int n = 0; n < ND; n++) m_dac[n] = '0;
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk("R1", "cfg1/2/3", 32'(cfg1_o | cfg2_o | cfg3_o), 32'h0);
    chk("R1", "dio", 32'({dio_o, dio_oe_o}), 32'h0);
    chk("R1", "strobes", 32'({fifo_clr_o, fifo_wr_o, tc_clr_o, int1_clr_o, int2_clr_o, dac_wr_o}), 32'h0);
    chk("R1", "dac code ch0", 32'(dac_code_o[CW-1:0]), 32'h800);
    rst_ni = 1'b1;
    // R2 init pulses on first edge
    @(posedge clk_i); model_edge(); @(negedge clk_i); compare_all("R2");
    chk("R2", "init pulse", 32'({fifo_clr_o, tc_clr_o, int1_clr_o, int2_clr_o}), 32'hF);
    step(0, 0, 4'd0, 16'h0, 3'b000);
    chk("R2", "init pulse gone", 32'({fifo_clr_o, tc_clr_o, int1_clr_o, int2_clr_o}), 32'h0);

    // R4 unbanked registers
    step(1, 0, 4'd1, 16'h1234, 3'b000);
    step(1, 0, 4'd0, 16'h00A5, 3'b000);
    dio_i = 8'h3C;
    step(0, 1, 4'd0, 16'h0, 3'b000);           // R10 all input
    step(1, 0, 4'd2, 16'h0004, 3'b000);         // R9 low nibble out
    step(0, 1, 4'd0, 16'h0, 3'b000);
    step(1, 0, 4'd2, 16'h0008, 3'b000);         // R9 high nibble out
    step(0, 1, 4'd0, 16'h0, 3'b000);

    // R6 events and R5 status
    fifo_half_i = 1; fifo_full_i = 1; prom_i = 1;
    step(0, 0, 4'd0, 16'h0, 3'b011);
    step(0, 1, 4'd5, 16'h0, 3'b100);
    flag_check("R6", 3'b111);
    // R3 set bank, clear int1 with data ignored
    step(1, 0, 4'd5, 16'h0080, 3'b000);
    step(1, 0, 4'd1, 16'hFFFF, 3'b000);
    chk("R3", "cfg2 kept", 32'(cfg2_o), 32'h1234);
    flag_check("R6", 3'b101);
    // clear tc with a coincident tc event: stays set
    step(1, 0, 4'd0, 16'hFFFF, 3'b001);
    flag_check("R6", 3'b101);
    step(1, 0, 4'd2, 16'hFFFF, 3'b000);
    flag_check("R6", 3'b001);
    // R7 banked write at FIFO offset goes to DAC channel 0
    step(1, 0, 4'd6, 16'h0123, 3'b000);
    chk("R7", "dac0 code", 32'(dac_code_o[CW-1:0]), 32'h923);
    step(1, 0, 4'd7, 16'h0F00, 3'b000);        // R8 ch1 while banked
    step(1, 0, 4'd5, 16'h0000, 3'b000);
    step(1, 0, 4'd6, 16'hBEEF, 3'b000);        // R7 fifo push
    step(1, 0, 4'd15, 16'h07FF, 3'b000);       // R8 last channel
    chk("R8", "dac9 code", 32'(dac_code_o[9*CW +: CW]), 32'hFFF);
    step(0, 1, 4'd6, 16'h0, 3'b000);           // R7 fifo clear on read
    step(0, 1, 4'd3, 16'h0, 3'b000);           // R11 unmapped read

    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 3);
      dio_i = 8'($urandom);
      {fifo_half_i, fifo_empty_i, fifo_full_i, prom_i} = 4'($urandom);
      step(op == 1, op == 2, 4'($urandom), 16'($urandom),
           (($urandom % 4) == 0) ? 3'($urandom) : 3'b000);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule